// File: doc/BRIEF.md
# Processor Load/Store to Avalon-MM Master Bridge

The bridge takes one load or store at a time from a simple processor-side request port and turns it into single Avalon memory-mapped master transfers. The processor presents a one-cycle request strobe together with a byte address, store data, an access size and a direction flag. It then waits for a one-cycle acknowledge, which carries the load result.

Byte, halfword and word accesses are accepted at any byte address. The Avalon address is always word aligned, and the lanes that take part in a transfer are chosen with byteenable. Store data is steered onto the matching lanes, and load data is taken from those lanes and returned right-justified. An access whose bytes reach past the end of a 32-bit word becomes two transfers in sequence: first the lower word, then the next word. The acknowledge follows the last of them.

Only one transfer is ever in flight. The slave may stretch any transfer with waitrequest for any number of cycles.

Top module: `pbav_bridge`

## Requirements
- R1: At most one of `avm_read` and `avm_write` is high in any cycle. Each transfer is a single read or write, and `avm_address[1:0]` is always 0.
- R2: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. For an access that fits in one word at byte offset n = `req_addr[1:0]`, `avm_byteenable` is 1<<n for a byte, 3<<n for a halfword and 4'b1111 for a word.
- R3: When the bytes of an access reach past lane 3, the bridge makes two transfers. The first goes to the word holding `req_addr` with the lanes from n upward. The second goes to the next word address (+4) with the remaining low lanes.
- R4: While `avm_read` or `avm_write` is high and `avm_waitrequest` is high, the strobe, address, byteenable and writedata do not change. A transfer completes in the cycle in which its strobe is high and `avm_waitrequest` is low.
- R5: On a store, byte k of `req_wdata` appears on `avm_writedata` lane (n+k) mod 4, in each transfer that enables that lane.
- R6: On a load, byte k of `rdata` is the memory byte at address `req_addr`+k. It is captured from `avm_readdata` in the completing cycle, and bytes above the access size read as zero.
- R7: `ack` is high for exactly one cycle, the cycle after the last transfer completes. No transfer strobe is high during that cycle, and `rdata` is valid in it.
- R8: A request is accepted when `req_valid` is high in an idle cycle. Its first transfer strobe is high in the next cycle.
- R9: A `req_valid` pulse that arrives while a transfer is in progress or during the `ack` cycle is ignored, and it causes no later transfer.
- R10: Synchronous active-high `rst` abandons any access. In the cycle after a reset edge, `avm_read`, `avm_write` and `ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Store data, right-justified |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_we | input | 1 | 1 store, 0 load |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Load result, zero-extended, valid with ack |
| avm_address | output | ADDR_W | Word-aligned byte address |
| avm_byteenable | output | 4 | Active byte lanes |
| avm_read | output | 1 | Read strobe |
| avm_write | output | 1 | Write strobe |
| avm_writedata | output | 32 | Lane-steered store data |
| avm_waitrequest | input | 1 | Slave stall |
| avm_readdata | input | 32 | Slave read data |

## Verification
Suppose a request is sampled at clock edge E. The first strobe, its address and its byteenable are due in the cycle after E. The transfer then ends at the first later edge at which waitrequest is low. A split access starts its second transfer in the next cycle, and `ack` with `rdata` follows one cycle after the last completing edge. The bench keeps a behavioural model that moves through those same phases from the waitrequest values it drives itself. It samples every output one time unit after each rising edge and compares strobes, address, byteenable, enabled writedata lanes, `ack` and `rdata` against the model in every cycle.

// File: rtl/pbav_pkg.sv
package pbav_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic [1:0]        off;
        logic [1:0]        size;
        logic [LANES-1:0]  be_lo;
        logic [LANES-1:0]  be_hi;
        logic [DATA_W-1:0] wdata_rot;
    } job_t;

    function automatic logic [LANES-1:0] size_lanes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_lanes = 4'b0001;
            SZ_HALF: size_lanes = 4'b0011;
            default: size_lanes = 4'b1111;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lanes_to_bits(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] rot_up(input logic [DATA_W-1:0] d, input logic [1:0] off);
        logic [2*DATA_W-1:0] dd;
        dd = {d, d} >> (DATA_W - 8 * int'(off));
        return dd[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] rot_down(input logic [DATA_W-1:0] d, input logic [1:0] off);
        logic [2*DATA_W-1:0] dd;
        dd = {d, d} >> (8 * int'(off));
        return dd[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] trim_to_size(input logic [DATA_W-1:0] d, input logic [1:0] sz);
        return d & lanes_to_bits(size_lanes(sz));
    endfunction

endpackage

// File: rtl/pbav_lane_map.sv
module pbav_lane_map
    import pbav_pkg::*;
(
    input  logic [1:0]       off,
    input  logic [1:0]       size,
    output logic [LANES-1:0] be_lo,
    output logic [LANES-1:0] be_hi
);
    logic [2*LANES-1:0] span;

    always_comb begin
        span  = {{LANES{1'b0}}, size_lanes(size)} << off;
        be_lo = span[LANES-1:0];
        be_hi = span[2*LANES-1:LANES];
    end
endmodule

// File: rtl/pbav_sequencer.sv
module pbav_sequencer
    import pbav_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [LANES-1:0]  be_lo_in,
    input  logic [LANES-1:0]  be_hi_in,
    input  logic              avm_waitrequest,
    output logic [ADDR_W-1:0] avm_address,
    output logic [LANES-1:0]  avm_byteenable,
    output logic              avm_read,
    output logic              avm_write,
    output logic [DATA_W-1:0] avm_writedata,
    output logic              ack,
    output logic              start,
    output logic              last_done,
    output logic [1:0]        off_q,
    output logic [1:0]        size_q
);
    localparam int WORD_W = ADDR_W - 2;

    seq_state_e        state;
    job_t              job;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_next;
    logic              active;
    logic              done;

    assign start     = (state == ST_IDLE) && req_valid;
    assign active    = (state == ST_LOW) || (state == ST_HIGH);
    assign done      = active && !avm_waitrequest;
    assign last_done = done && ((state == ST_HIGH) || (job.be_hi == '0));
    assign word_next = word_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            job    <= '0;
            word_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state         <= ST_LOW;
                    word_q        <= req_addr[ADDR_W-1:2];
                    job.we        <= req_we;
                    job.off       <= req_addr[1:0];
                    job.size      <= req_size;
                    job.be_lo     <= be_lo_in;
                    job.be_hi     <= be_hi_in;
                    job.wdata_rot <= rot_up(req_wdata, req_addr[1:0]);
                end
                ST_LOW:  if (done) state <= (job.be_hi != '0) ? ST_HIGH : ST_RESP;
                ST_HIGH: if (done) state <= ST_RESP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        avm_address    = {((state == ST_HIGH) ? word_next : word_q), 2'b00};
        avm_byteenable = (state == ST_HIGH) ? job.be_hi : job.be_lo;
        avm_read       = active && !job.we;
        avm_write      = active && job.we;
        avm_writedata  = job.wdata_rot;
        ack            = (state == ST_RESP);
        off_q          = job.off;
        size_q         = job.size;
    end
endmodule

// File: rtl/pbav_rd_merge.sv
module pbav_rd_merge
    import pbav_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture,
    input  logic              finish,
    input  logic [LANES-1:0]  cap_be,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [1:0]        off,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] merged;

    assign merged = acc | (bus_data & lanes_to_bits(cap_be));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            rdata <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (capture) begin
            acc <= merged;
            if (finish) begin
                rdata <= trim_to_size(rot_down(merged, off), size);
            end
        end
    end
endmodule

// File: rtl/pbav_bridge.sv
module pbav_bridge
    import pbav_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    output logic              ack,
    output logic [31:0]       rdata,
    output logic [ADDR_W-1:0] avm_address,
    output logic [3:0]        avm_byteenable,
    output logic              avm_read,
    output logic              avm_write,
    output logic [31:0]       avm_writedata,
    input  logic              avm_waitrequest,
    input  logic [31:0]       avm_readdata
);
    logic [LANES-1:0] be_lo;
    logic [LANES-1:0] be_hi;
    logic             start;
    logic             last_done;
    logic [1:0]       off_q;
    logic [1:0]       size_q;

    pbav_lane_map u_map (
        .off   (req_addr[1:0]),
        .size  (req_size),
        .be_lo (be_lo),
        .be_hi (be_hi)
    );

    pbav_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .req_size        (req_size),
        .req_we          (req_we),
        .be_lo_in        (be_lo),
        .be_hi_in        (be_hi),
        .avm_waitrequest (avm_waitrequest),
        .avm_address     (avm_address),
        .avm_byteenable  (avm_byteenable),
        .avm_read        (avm_read),
        .avm_write       (avm_write),
        .avm_writedata   (avm_writedata),
        .ack             (ack),
        .start           (start),
        .last_done       (last_done),
        .off_q           (off_q),
        .size_q          (size_q)
    );

    pbav_rd_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .capture  (avm_read && !avm_waitrequest),
        .finish   (last_done),
        .cap_be   (avm_byteenable),
        .bus_data (avm_readdata),
        .off      (off_q),
        .size     (size_q),
        .rdata    (rdata)
    );
endmodule

// File: rtl/pbav_checker.sv
module pbav_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic [ADDR_W-1:0] avm_address,
    input logic [3:0]        avm_byteenable,
    input logic              avm_read,
    input logic              avm_write,
    input logic [31:0]       avm_writedata,
    input logic              avm_waitrequest
);
    // R1
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(avm_read && avm_write));

    // R1
    addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (avm_read || avm_write) |-> (avm_address[1:0] == 2'b00));

    // R2
    lanes_present_chk: assert property (@(posedge clk) disable iff (rst)
        (avm_read || avm_write) |-> (avm_byteenable != 4'b0000));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((avm_read || avm_write) && avm_waitrequest) |=>
        ($stable(avm_read) && $stable(avm_write) && $stable(avm_address)
         && $stable(avm_byteenable) && $stable(avm_writedata)));

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R7
    ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> !(avm_read || avm_write));
endmodule

bind pbav_bridge pbav_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pbav_bridge_tb.sv
`timescale 1ns/1ps
module pbav_bridge_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [1:0]  req_size;
    logic        req_we;
    logic        ack;
    logic [31:0] rdata;
    logic [31:0] avm_address;
    logic [3:0]  avm_byteenable;
    logic        avm_read;
    logic        avm_write;
    logic [31:0] avm_writedata;
    logic        avm_waitrequest;
    logic [31:0] avm_readdata;

    always #2.5 clk = ~clk;

    pbav_bridge #(.ADDR_W(32)) u_dut (.*);

    logic [7:0] mem [256];
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            avm_readdata[8*i +: 8] = mem[{avm_address[7:2], 2'(i)}];
        end
    end

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
        logic        we;
    } op_t;
    op_t ops[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int          mph = 0;
    logic [29:0] mword;
    logic [3:0]  mbe_lo, mbe_hi;
    logic        mwe;
    logic [31:0] mwd_lane;
    logic [31:0] mexp_rd;
    bit          tag_rst = 0;
    bit          tag_noise = 0;
    bit          tag_stall = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_cycle();
        logic exp_rd, exp_wr;
        logic [31:0] m;
        string st;
        exp_rd = (mph == 1 || mph == 2) && !mwe;
        exp_wr = (mph == 1 || mph == 2) && mwe;
        st = tag_rst ? "R10 strobes after reset" : (tag_noise ? "R9 strobes with busy request" : "R8 strobes");
        chk(avm_read === exp_rd, {st, " read"}, 32'(avm_read), 32'(exp_rd));
        chk(avm_write === exp_wr, {st, " write"}, 32'(avm_write), 32'(exp_wr));
        chk(ack === (mph == 3), tag_rst ? "R10 ack after reset" : "R7 ack", 32'(ack), 32'(mph == 3));
        if (mph == 1) begin
            chk(avm_address === {mword, 2'b00}, tag_stall ? "R4 address held" : "R1 address",
                avm_address, {mword, 2'b00});
            chk(avm_byteenable === mbe_lo, "R2 byteenable", 32'(avm_byteenable), 32'(mbe_lo));
        end
        if (mph == 2) begin
            chk(avm_address === {mword + 30'd1, 2'b00}, "R3 second address",
                avm_address, {mword + 30'd1, 2'b00});
            chk(avm_byteenable === mbe_hi, "R3 second byteenable", 32'(avm_byteenable), 32'(mbe_hi));
        end
        if ((mph == 1 || mph == 2) && mwe) begin
            for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{avm_byteenable[i]}};
            chk((avm_writedata & m) === (mwd_lane & m), "R5 writedata lanes",
                avm_writedata & m, mwd_lane & m);
        end
        if (mph == 3 && !mwe) begin
            chk(rdata === mexp_rd, "R6 rdata", rdata, mexp_rd);
        end
        if (mph == 0) tag_noise = 0;
        tag_rst = 0;
    endtask

    task automatic accept(input op_t o);
        int n;
        int lane;
        n = (o.size == 2'd0) ? 1 : (o.size == 2'd1) ? 2 : 4;
        mword = o.addr[31:2];
        mwe = o.we;
        mbe_lo = '0;
        mbe_hi = '0;
        mwd_lane = '0;
        mexp_rd = '0;
        for (int k = 0; k < n; k++) begin
            lane = int'(o.addr[1:0]) + k;
            if (lane < 4) mbe_lo[lane] = 1'b1;
            else mbe_hi[lane - 4] = 1'b1;
            mwd_lane[8*(lane % 4) +: 8] = o.data[8*k +: 8];
            mexp_rd[8*k +: 8] = mem[8'(o.addr + 32'(k))];
        end
    endtask

    initial begin
        int qi = 0;
        int gap = 0;
        int idle = 0;
        bit wmode = 0;
        bit mid_reset_done = 0;
        op_t o;

        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        // directed: every size at every offset, store then load back
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 4; off++) begin
                o.addr = 32'h40 + 32'(16 * (sz * 4 + off)) + 32'(off);
                o.data = $urandom();
                o.size = 2'(sz);
                o.we = 1'b1;
                ops.push_back(o);
                o.we = 1'b0;
                ops.push_back(o);
            end
        end
        // word split across the top of the modelled space
        o.addr = 32'hFE; o.data = 32'hA1B2C3D4; o.size = 2'd2; o.we = 1'b1;
        ops.push_back(o);
        o.we = 1'b0;
        ops.push_back(o);
        for (int i = 0; i < 300; i++) begin
            o.addr = $urandom();
            o.data = $urandom();
            o.size = 2'($urandom_range(0, 2));
            o.we = 1'($urandom_range(0, 1));
            ops.push_back(o);
        end

        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0;
        req_wdata = '0;
        req_size = '0;
        req_we = 1'b0;
        avm_waitrequest = 1'b0;

        for (int cyc = 0; cyc < 150000; cyc++) begin
            @(posedge clk);
            #1;
            compare_cycle();

            wmode = (qi > 26);
            // reset choice for the coming edge
            if (cyc < 4) begin
                rst = 1'b1;
                tag_rst = 1;
            end else if (!mid_reset_done && qi == 40 && mph == 1) begin
                rst = 1'b1;
                mid_reset_done = 1;
                tag_rst = 1;
            end else begin
                rst = 1'b0;
            end
            avm_waitrequest = wmode ? 1'($urandom_range(0, 1)) : 1'b0;
            tag_stall = (mph == 1 || mph == 2) && avm_waitrequest;

            req_valid = 1'b0;
            if (!rst && mph == 0 && gap == 0 && qi < ops.size()) begin
                o = ops[qi];
                qi++;
                req_valid = 1'b1;
                req_addr = o.addr;
                req_wdata = o.data;
                req_size = o.size;
                req_we = o.we;
                gap = $urandom_range(0, 2);
            end else if (mph != 0 && $urandom_range(0, 3) == 0) begin
                req_valid = 1'b1;
                req_addr = $urandom();
                req_wdata = $urandom();
                req_size = 2'($urandom_range(0, 2));
                req_we = 1'($urandom_range(0, 1));
                tag_noise = 1;
            end else if (mph == 0 && gap > 0) begin
                gap--;
            end

            // slave completes a write at the coming edge
            if (avm_write && !avm_waitrequest) begin
                for (int i = 0; i < 4; i++) begin
                    if (avm_byteenable[i]) mem[{avm_address[7:2], 2'(i)}] = avm_writedata[8*i +: 8];
                end
            end

            // advance model to the state after the coming edge
            if (rst) begin
                mph = 0;
            end else begin
                case (mph)
                    0: if (req_valid) begin
                        accept(o);
                        mph = 1;
                    end
                    1: if (!avm_waitrequest) mph = (mbe_hi != 4'b0) ? 2 : 3;
                    2: if (!avm_waitrequest) mph = 3;
                    default: mph = 0;
                endcase
            end

            if (qi >= ops.size() && mph == 0) idle++;
            else idle = 0;
            if (idle > 4) break;
        end
        if (qi < ops.size() || mph != 0) begin
            n_bad++;
            $display("FAIL R8 run did not drain: actual=%0d expected=%0d", qi, ops.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R8 watchdog expired: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule